// File: doc/BRIEF.md
# Sequential Signed Multiply/Divide Unit with Result Register Pair

This unit performs signed 32-bit multiplication and division over many clock cycles and keeps the outcome in two dedicated result registers, HI and LO, rather than in a general register. A single-cycle start pulse, together with an operation select and two operands, begins a calculation. The unit raises busy while it iterates. When it finishes, both result registers update together. A multiply fills HI with the upper half of the 64-bit product and LO with the lower half. A divide puts the remainder in HI and the quotient in LO, so the two operations use the register pair in opposite roles.

Each result register can be read at all times. Each can also be loaded directly through its own write port, for example to restore saved state after a context switch. The datapath uses a radix-2 shift-add multiplier and a restoring divider. Both work on operand magnitudes, take 32 iteration cycles, and then spend one extra cycle applying signs and writing the results.

Top module: `mdu_hilo`

## Requirements
- R1: With opSel = 0 (multiply), operands are signed two's complement. On completion HI holds bits 63..32 and LO holds bits 31..0 of the signed 64-bit product.
- R2: With opSel = 1 (divide) and a nonzero divisor, LO receives the quotient truncated toward zero and HI receives the remainder. The remainder has the sign of the dividend.
- R3: busy goes high in the cycle after an accepted start. It stays high for exactly 33 cycles and falls in the same cycle that HI and LO take their new values.
- R4: A start pulse while busy is high is ignored. Its operands and operation are not captured, and the running operation finishes with its original result and timing.
- R5: During an operation, HI and LO keep their previous values until completion. Both then change in the same cycle.
- R6: Division by zero takes the normal 33 busy cycles, leaves HI and LO unchanged, and raises no indication.
- R7: When no result is being written, hiWrEn loads hiWrData into HI and loWrEn loads loWrData into LO at the next clock edge, each independently. This works whether or not the unit is busy.
- R8: If a direct write falls in the completion cycle, the computed result wins for both registers. The exception is a divide by zero: it writes nothing, so the direct write takes effect.
- R9: A synchronous reset clears HI, LO and busy, even in the middle of an operation.
- R10: Dividing -2^31 by -1 yields LO = 0x80000000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opSel | input | 1 | 0 = signed multiply, 1 = signed divide |
| opA | input | 32 | Multiplicand / dividend |
| opB | input | 32 | Multiplier / divisor |
| hiWrEn | input | 1 | Direct load enable for HI |
| hiWrData | input | 32 | Direct load value for HI |
| loWrEn | input | 1 | Direct load enable for LO |
| loWrData | input | 32 | Direct load value for LO |
| busy | output | 1 | Operation in progress |
| hiOut | output | 32 | HI register contents |
| loOut | output | 32 | LO register contents |

## Verification
The completion write from the iterative engine and a direct write to HI or LO can land on the same clock edge. The bench counts busy cycles and raises hiWrEn and loWrEn with marker values so that they are sampled exactly on the commit edge. It does this for an ordinary multiply, an ordinary divide, and a divide by zero. The registers must then show the computed result in the first two cases and the marker values in the third, while a direct write made earlier in the operation must show up at once and later be replaced.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  parameter int DATA_W = 32;
  localparam int ITER = DATA_W;
  localparam int CNT_W = $clog2(ITER + 1);

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } mduOp_e;

  typedef struct packed {
    logic load;    // capture operands, initialise work register
    logic step;    // one shift-add / restoring iteration
    logic commit;  // sign fix-up and HI/LO update
  } mduStrobes_t;
endpackage

// File: rtl/mdu_control.sv
module mdu_control
  import mdu_pkg::*;
#(
  parameter int STEPS = ITER
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output mduStrobes_t strobes
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS);

  logic [CW-1:0] cnt;

  always_comb begin
    strobes.load   = start && !busy;
    strobes.step   = busy && (cnt != LAST);
    strobes.commit = busy && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strobes.load) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (strobes.commit) begin
      busy <= 1'b0;
    end else if (strobes.step) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> busy && cnt == '0);
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.commit |=> !busy);
  p_start_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> busy && cnt == $past(cnt) + 1'b1);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> !busy);
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  mduStrobes_t  strobes,
  input  logic         opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         hiWrEn,
  input  logic [W-1:0] hiWrData,
  input  logic         loWrEn,
  input  logic [W-1:0] loWrData,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  localparam int WW = 2 * W;

  logic [WW-1:0] work;       // mult: {partial, multiplier}; div: {remainder, quotient}
  logic [W-1:0]  magOther;   // multiplicand or divisor magnitude
  logic          opReg, negMain, negRem, zeroDiv;
  logic [W-1:0]  hiReg, loReg;

  logic [W-1:0]  magA, magB;
  logic [W:0]    addSum, shifted, diff;
  logic [WW-1:0] workNext, mulRes;
  logic [W-1:0]  resHi, resLo;
  logic          writeRes;

  always_comb begin
    magA = opA[W-1] ? -opA : opA;
    magB = opB[W-1] ? -opB : opB;

    addSum  = {1'b0, work[WW-1:W]} + (work[0] ? {1'b0, magOther} : '0);
    shifted = {work[WW-1:W], work[W-1]};
    diff    = shifted - {1'b0, magOther};

    if (opReg == OP_DIV)
      workNext = diff[W] ? {shifted[W-1:0], work[W-2:0], 1'b0}
                         : {diff[W-1:0],    work[W-2:0], 1'b1};
    else
      workNext = {addSum, work[W-1:1]};

    mulRes = negMain ? -work : work;
    if (opReg == OP_DIV) begin
      resLo = negMain ? -work[W-1:0] : work[W-1:0];
      resHi = negRem  ? -work[WW-1:W] : work[WW-1:W];
    end else begin
      resLo = mulRes[W-1:0];
      resHi = mulRes[WW-1:W];
    end
    writeRes = strobes.commit && !(opReg == OP_DIV && zeroDiv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work     <= '0;
      magOther <= '0;
      opReg    <= 1'b0;
      negMain  <= 1'b0;
      negRem   <= 1'b0;
      zeroDiv  <= 1'b0;
    end else if (strobes.load) begin
      opReg    <= opSel;
      negMain  <= opA[W-1] ^ opB[W-1];
      negRem   <= opA[W-1];
      zeroDiv  <= (opB == '0);
      magOther <= (opSel == OP_DIV) ? magB : magA;
      work     <= {{W{1'b0}}, ((opSel == OP_DIV) ? magA : magB)};
    end else if (strobes.step) begin
      work <= workNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (writeRes) begin
      hiReg <= resHi;
      loReg <= resLo;
    end else begin
      if (hiWrEn) hiReg <= hiWrData;
      if (loWrEn) loReg <= loWrData;
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

  p_rem_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (strobes.commit && opReg == OP_DIV && !zeroDiv) |-> work[WW-1:W] < magOther);
  p_hold_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobes.commit && !hiWrEn) |=> $stable(hiReg));
  p_hold_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobes.commit && !loWrEn) |=> $stable(loReg));
  p_div0_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (strobes.commit && opReg == OP_DIV && zeroDiv && !hiWrEn && !loWrEn)
      |=> $stable(hiReg) && $stable(loReg));
  p_direct_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (!strobes.commit && hiWrEn) |=> hiReg == $past(hiWrData));
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> hiReg == '0 && loReg == '0);
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         hiWrEn,
  input  logic [W-1:0] hiWrData,
  input  logic         loWrEn,
  input  logic [W-1:0] loWrData,
  output logic         busy,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  mduStrobes_t strobes;

  mdu_control #(.STEPS(W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .strobes(strobes)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .opSel(opSel),
    .opA(opA), .opB(opB),
    .hiWrEn(hiWrEn), .hiWrData(hiWrData),
    .loWrEn(loWrEn), .loWrData(loWrData),
    .hiOut(hiOut), .loOut(loOut)
  );
endmodule

// File: tb/tb_mdu_hilo.sv
`timescale 1ns/1ps
module tb_mdu_hilo;
  logic clk = 1'b0;
  logic rst, start, opSel, hiWrEn, loWrEn, busy;
  logic [31:0] opA, opB, hiWrData, loWrData, hiOut, loOut;
  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] expHi = 0, expLo = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mdu_hilo dut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result model: returns 1 if results are written
  function automatic bit model(input bit isDiv, input logic [31:0] a, input logic [31:0] b,
                               output logic [31:0] h, output logic [31:0] l);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint p, q, r;
    if (!isDiv) begin
      p = sa * sb;
      h = p[63:32]; l = p[31:0];
      return 1;
    end
    if (b == 0) begin h = 0; l = 0; return 0; end
    q = sa / sb; r = sa % sb;
    h = r[31:0]; l = q[31:0];
    return 1;
  endfunction

  // run one operation; injAt>0 drives a second start at that busy cycle;
  // wrAtEnd drives both direct writes so they are sampled on the commit edge
  task automatic runOp(input bit isDiv, input logic [31:0] a, input logic [31:0] b,
                       input int injAt, input bit wrAtEnd, input string tag);
    logic [31:0] h, l, oldHi, oldLo;
    bit wr;
    int n;
    wr = model(isDiv, a, b, h, l);
    oldHi = hiOut; oldLo = loOut;
    @(negedge clk);
    start = 1; opSel = isDiv; opA = a; opB = b;
    @(negedge clk);
    start = 0; opA = 32'h5A5A_1234; opB = 32'h0000_0003; opSel = ~isDiv;
    check(busy === 1'b1, {"R3 busy after start ", tag}, busy, 1);
    n = 0;
    while (busy === 1'b1 && n < 100) begin
      n++;
      if (!(wrAtEnd && n == 34))
        check(hiOut === oldHi && loOut === oldLo, {"R5 hold during op ", tag},
              {hiOut, loOut}, {oldHi, oldLo});
      start = (injAt == n);
      if (wrAtEnd && n == 33) begin
        hiWrEn = 1; loWrEn = 1; hiWrData = 32'hDEAD_0001; loWrData = 32'hBEEF_0002;
      end else begin
        hiWrEn = 0; loWrEn = 0;
      end
      @(negedge clk);
    end
    start = 0; hiWrEn = 0; loWrEn = 0;
    check(n == 33, {"R3 busy length ", tag}, n, 33);
    if (wr) begin expHi = h; expLo = l; end
    else if (wrAtEnd) begin expHi = 32'hDEAD_0001; expLo = 32'hBEEF_0002; end
    else begin expHi = oldHi; expLo = oldLo; end
    check(hiOut === expHi && loOut === expLo, {"R1/R2/R6/R8 result ", tag},
          {hiOut, loOut}, {expHi, expLo});
  endtask

  initial begin
    rst = 1; start = 0; opSel = 0; opA = 0; opB = 0;
    hiWrEn = 0; loWrEn = 0; hiWrData = 0; loWrData = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    check(hiOut === 0 && loOut === 0 && busy === 0, "R9 reset state", {hiOut, loOut}, 0);

    // R7 direct writes while idle, independently
    hiWrEn = 1; hiWrData = 32'h1111_2222;
    @(negedge clk);
    hiWrEn = 0; loWrEn = 1; loWrData = 32'h3333_4444;
    @(negedge clk);
    loWrEn = 0;
    check(hiOut === 32'h1111_2222 && loOut === 32'h3333_4444, "R7 direct idle writes",
          {hiOut, loOut}, 64'h1111_2222_3333_4444);

    // R1 directed products
    runOp(0, 32'd7, 32'd6, 0, 0, "mul small");
    runOp(0, 32'hFFFF_FFFD, 32'd5, 0, 0, "mul neg*pos");
    runOp(0, 32'h8000_0000, 32'h8000_0000, 0, 0, "mul minneg^2");
    runOp(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "mul -1*-1");
    // R2 directed quotients / remainders, all sign combos
    runOp(1, 32'd17, 32'd5, 0, 0, "div ++");
    runOp(1, -32'sd17, 32'd5, 0, 0, "div -+");
    runOp(1, 32'd17, -32'sd5, 0, 0, "div +-");
    runOp(1, -32'sd17, -32'sd5, 0, 0, "div --");
    // R10 overflow case
    runOp(1, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, "R10 minneg/-1");
    check(loOut === 32'h8000_0000 && hiOut === 0, "R10 overflow quotient", {hiOut, loOut}, 64'h8000_0000);
    // R6 divide by zero keeps HI/LO
    runOp(1, 32'd99, 32'd0, 0, 0, "R6 div0");
    // R4 start while busy ignored
    runOp(0, 32'd1234, 32'd5678, 5, 0, "R4 restart ignored");
    check(busy === 0, "R4 no second op", busy, 0);
    // R8 collisions of commit and direct write
    runOp(0, 32'd300, 32'hFFFF_FF00, 0, 1, "R8 mul vs write");
    runOp(1, 32'd1000, 32'd7, 0, 1, "R8 div vs write");
    runOp(1, 32'd1000, 32'd0, 0, 1, "R8 div0 vs write");

    // R7 direct write during busy, later overwritten by commit
    @(negedge clk);
    start = 1; opSel = 0; opA = 32'd3; opB = 32'd4;
    @(negedge clk);
    start = 0; hiWrEn = 1; hiWrData = 32'hCAFE_F00D;
    @(negedge clk);
    hiWrEn = 0;
    check(hiOut === 32'hCAFE_F00D, "R7 direct write while busy", hiOut, 32'hCAFE_F00D);
    while (busy) @(negedge clk);
    check(hiOut === 0 && loOut === 32'd12, "R7 commit replaces", {hiOut, loOut}, 64'd12);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ra, rb;
      bit rd;
      ra = $urandom; rb = $urandom; rd = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) rb = rb >> $urandom_range(16, 31);
      if ($urandom_range(0, 9) == 0) rb = 0;
      runOp(rd, ra, rb, 0, 0, rd ? "R2 random div" : "R1 random mul");
    end

    // R9 reset mid operation
    @(negedge clk);
    start = 1; opSel = 1; opA = 32'd50; opB = 32'd3;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(busy === 0 && hiOut === 0 && loOut === 0, "R9 reset mid-op", {hiOut, loOut}, 0);
    repeat (40) @(negedge clk);
    check(busy === 0 && hiOut === 0 && loOut === 0, "R9 stays idle after reset", {hiOut, loOut}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule